// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of page translations. Each entry holds a virtual page number, an address-space identifier and a physical page number. It also holds access-permission bits and a dirty flag. A request supplies a virtual address, the current address-space identifier and an access kind. One clock later the block reports one of four outcomes: a hit with the physical address, a plain miss, a protection fault, or a dirty-update miss. The low page-offset bits pass through untranslated and are appended to the physical page number.

Because entries carry the identifier, a context switch does not have to empty the buffer. An outside page walker installs translations through a refill port. Two maintenance commands are available: a flush that invalidates every entry, and a selective flush that invalidates only the entries of one identifier. A refill goes to an entry that already holds the same page and identifier. If there is none, it goes to the lowest-numbered empty entry. If there is no empty entry, it goes to the entry named by a rotating replacement pointer.

A response state machine holds the outcome of the previous cycle's request. Its states are RS_IDLE, RS_HIT, RS_MISS, RS_FAULT and RS_DIRTY. Every clock edge moves it to the state that classifies the request presented in that cycle, and to RS_IDLE when there is no request. Any state can reach any other state in one edge.

Top module: `tlb_xlate_top`

## Requirements
- R1: After reset every entry is invalid and `rsp_valid` is low, so the first lookup reports a miss.
- R2: A request sampled at clock edge k that hits raises `rsp_valid` and `rsp_hit` after edge k for exactly one cycle. `rsp_paddr` equals the entry's physical page number followed by the request's 13 page-offset bits.
- R3: A lookup matches only a valid entry whose page number and address-space identifier both equal the request's. The same page under another identifier misses, and each identifier gets its own translation.
- R4: Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. Access code 0 is read, 1 is write, 2 is execute, and 3 is never permitted. A matching entry that lacks the requested right gives `rsp_fault` instead of `rsp_hit`.
- R5: A permitted write that matches an entry whose dirty flag is clear gives `rsp_dirty_miss` and not `rsp_hit`. A read of the same entry hits. A fault takes precedence over a dirty-update miss.
- R6: `flush_all` invalidates every entry within one clock and returns the replacement pointer to entry 0. A refill presented in the same cycle as any flush is dropped.
- R7: A selective flush invalidates exactly the entries tagged with `flush_asid` and leaves all other entries usable.
- R8: A refill whose page and identifier match a valid entry overwrites that entry, so no second copy is made and no other entry is consumed.
- R9: When the refill does not match a valid entry and an entry is free, the refill goes to the lowest-numbered free entry. The replacement pointer is left unchanged.
- R10: When all entries are valid and none matches, the refill replaces the entry named by the replacement pointer. The pointer then advances by one and wraps.
- R11: A request with no matching entry gives `rsp_miss`. At most one of the four outcome flags is high at a time, and `rsp_valid` is high exactly when one of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 43 | Virtual address of the request |
| req_asid | input | 8 | Current address-space identifier |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | A response is presented this cycle |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Matching entry forbids the access |
| rsp_dirty_miss | output | 1 | Write to a clean page; the walker must mark it dirty |
| rsp_paddr | output | 34 | Physical address for the last request |
| fill_valid | input | 1 | Refill strobe from the walker |
| fill_vpn | input | 30 | Virtual page number to install |
| fill_asid | input | 8 | Identifier to install |
| fill_ppn | input | 21 | Physical page number to install |
| fill_perm | input | 3 | Permission bits {execute, write, read} |
| fill_dirty | input | 1 | Dirty flag to install |
| flush_all | input | 1 | Invalidate every entry |
| flush_asid_en | input | 1 | Invalidate entries of one identifier |
| flush_asid | input | 8 | Identifier for the selective flush |

## Verification
The hardest behaviour to reach from the ports is the choice of victim. The buffer has to be full before the rotating pointer matters. The first-free rule can only be seen once a hole has been opened in a full buffer. To reach these cases, the stimulus first fills every entry. It then adds extra pages and checks which of the older pages stopped hitting. In a separate scenario, it fills every entry with one entry under a second identifier, removes that identifier with a selective flush, and checks that the next refill lands in the hole. The refill after that must evict entry 0. The duplicate-refill case is shown the same way. A second refill of one page followed by enough distinct pages to fill every slot must leave every page hitting.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        RS_IDLE  = 3'd0,
        RS_HIT   = 3'd1,
        RS_MISS  = 3'd2,
        RS_FAULT = 3'd3,
        RS_DIRTY = 3'd4
    } rsp_e;

    localparam int PERM_W   = 3;
    localparam int PERM_RD  = 0;
    localparam int PERM_WR  = 1;
    localparam int PERM_EX  = 2;

    function automatic logic perm_allows(input logic [PERM_W-1:0] perm, input acc_e acc);
        logic ok;
        unique case (acc)
            ACC_RD:  ok = perm[PERM_RD];
            ACC_WR:  ok = perm[PERM_WR];
            ACC_EX:  ok = perm[PERM_EX];
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_match.sv
`timescale 1ns/1ps
module tlb_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 30,
    parameter int ASID_W  = 8
) (
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [VPN_W-1:0]   vpn_arr  [ENTRIES],
    input  logic [ASID_W-1:0]  asid_arr [ENTRIES],
    input  logic [VPN_W-1:0]   key_vpn,
    input  logic [ASID_W-1:0]  key_asid,
    output logic [ENTRIES-1:0] hit_vec
);
    // One comparator per entry: valid, page and identifier must all agree.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = valid_vec[i]
                          && (vpn_arr[i]  == key_vpn)
                          && (asid_arr[i] == key_asid);
    end
endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
module tlb_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] dup_vec,
    input  logic               fill_go,
    input  logic               ptr_clear,
    output logic [IDX_W-1:0]   victim_idx
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] free_idx;
    logic             dup_any;
    logic             free_any;
    logic             use_rr;

    // Matching entry, if any (at most one exists).
    always_comb begin
        dup_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (dup_vec[i]) dup_idx = IDX_W'(i);
        end
    end
    assign dup_any = |dup_vec;

    // Lowest free entry: scan downward so the lowest index wins.
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx = IDX_W'(i);
        end
    end
    assign free_any = ~&valid_vec;

    assign use_rr = !dup_any && !free_any;

    always_comb begin
        if (dup_any)       victim_idx = dup_idx;
        else if (free_any) victim_idx = free_idx;
        else               victim_idx = rr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || ptr_clear) begin
            rr_q <= '0;
        end else if (fill_go && use_rr) begin
            if (rr_q == IDX_W'(ENTRIES - 1)) rr_q <= '0;
            else                             rr_q <= rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_store.sv
`timescale 1ns/1ps
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 30,
    parameter int PPN_W   = 21,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_all,
    input  logic               flush_asid_en,
    input  logic [ASID_W-1:0]  flush_asid,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [ASID_W-1:0]  wr_asid,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  logic [PERM_W-1:0]  wr_perm,
    input  logic               wr_dirty,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [ENTRIES-1:0] dirty_vec,
    output logic [VPN_W-1:0]   vpn_arr  [ENTRIES],
    output logic [ASID_W-1:0]  asid_arr [ENTRIES],
    output logic [PPN_W-1:0]   ppn_arr  [ENTRIES],
    output logic [PERM_W-1:0]  perm_arr [ENTRIES]
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic hit_wr;
        assign hit_wr = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n || flush_all) begin
                valid_vec[i] <= 1'b0;
            end else if (flush_asid_en) begin
                if (asid_arr[i] == flush_asid) valid_vec[i] <= 1'b0;
            end else if (hit_wr) begin
                valid_vec[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dirty_vec[i] <= 1'b0;
                vpn_arr[i]   <= '0;
                asid_arr[i]  <= '0;
                ppn_arr[i]   <= '0;
                perm_arr[i]  <= '0;
            end else if (hit_wr && !flush_all && !flush_asid_en) begin
                dirty_vec[i] <= wr_dirty;
                vpn_arr[i]   <= wr_vpn;
                asid_arr[i]  <= wr_asid;
                ppn_arr[i]   <= wr_ppn;
                perm_arr[i]  <= wr_perm;
            end
        end
    end
endmodule

// File: rtl/tlb_xlate_top.sv
`timescale 1ns/1ps
module tlb_xlate_top
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VA_W    = 43,
    parameter int OFF_W   = 13,
    parameter int PPN_W   = 21,
    parameter int ASID_W  = 8,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PA_W   = PPN_W + OFF_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [1:0]        req_acc,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic              rsp_dirty_miss,
    output logic [PA_W-1:0]   rsp_paddr,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [2:0]        fill_perm,
    input  logic              fill_dirty,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid
);
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] dirty_vec;
    logic [VPN_W-1:0]   vpn_arr  [ENTRIES];
    logic [ASID_W-1:0]  asid_arr [ENTRIES];
    logic [PPN_W-1:0]   ppn_arr  [ENTRIES];
    logic [PERM_W-1:0]  perm_arr [ENTRIES];

    logic [ENTRIES-1:0] look_hit;
    logic [ENTRIES-1:0] fill_dup;
    logic [IDX_W-1:0]   victim_idx;
    logic               fill_go;

    logic [VPN_W-1:0]   req_vpn;
    logic [OFF_W-1:0]   req_off;
    logic [PPN_W-1:0]   sel_ppn;
    logic [PERM_W-1:0]  sel_perm;
    logic               sel_dirty;
    logic               any_hit;

    rsp_e state_q, state_d;
    logic [PA_W-1:0] paddr_q;

    assign req_vpn = req_vaddr[VA_W-1:OFF_W];
    assign req_off = req_vaddr[OFF_W-1:0];
    assign fill_go = fill_valid && !flush_all && !flush_asid_en;

    tlb_store #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W),
        .ASID_W  (ASID_W)
    ) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush_all     (flush_all),
        .flush_asid_en (flush_asid_en),
        .flush_asid    (flush_asid),
        .wr_en         (fill_go),
        .wr_idx        (victim_idx),
        .wr_vpn        (fill_vpn),
        .wr_asid       (fill_asid),
        .wr_ppn        (fill_ppn),
        .wr_perm       (fill_perm),
        .wr_dirty      (fill_dirty),
        .valid_vec     (valid_vec),
        .dirty_vec     (dirty_vec),
        .vpn_arr       (vpn_arr),
        .asid_arr      (asid_arr),
        .ppn_arr       (ppn_arr),
        .perm_arr      (perm_arr)
    );

    tlb_match #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .ASID_W  (ASID_W)
    ) u_look (
        .valid_vec (valid_vec),
        .vpn_arr   (vpn_arr),
        .asid_arr  (asid_arr),
        .key_vpn   (req_vpn),
        .key_asid  (req_asid),
        .hit_vec   (look_hit)
    );

    tlb_match #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .ASID_W  (ASID_W)
    ) u_dup (
        .valid_vec (valid_vec),
        .vpn_arr   (vpn_arr),
        .asid_arr  (asid_arr),
        .key_vpn   (fill_vpn),
        .key_asid  (fill_asid),
        .hit_vec   (fill_dup)
    );

    tlb_victim #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_vec  (valid_vec),
        .dup_vec    (fill_dup),
        .fill_go    (fill_go),
        .ptr_clear  (flush_all),
        .victim_idx (victim_idx)
    );

    // OR-mux of the (at most one) matching entry's fields.
    always_comb begin
        sel_ppn   = '0;
        sel_perm  = '0;
        sel_dirty = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (look_hit[i]) begin
                sel_ppn   = sel_ppn   | ppn_arr[i];
                sel_perm  = sel_perm  | perm_arr[i];
                sel_dirty = sel_dirty | dirty_vec[i];
            end
        end
    end
    assign any_hit = |look_hit;

    // Next-state classification of the request in this cycle.
    always_comb begin
        if (!req_valid)                                   state_d = RS_IDLE;
        else if (!any_hit)                                state_d = RS_MISS;
        else if (!perm_allows(sel_perm, acc_e'(req_acc))) state_d = RS_FAULT;
        else if ((acc_e'(req_acc) == ACC_WR) && !sel_dirty) state_d = RS_DIRTY;
        else                                              state_d = RS_HIT;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         paddr_q <= '0;
        else if (req_valid) paddr_q <= {sel_ppn, req_off};
    end

    // Output decode.
    always_comb begin
        rsp_valid      = 1'b0;
        rsp_hit        = 1'b0;
        rsp_miss       = 1'b0;
        rsp_fault      = 1'b0;
        rsp_dirty_miss = 1'b0;
        unique case (state_q)
            RS_IDLE:  ;
            RS_HIT:   begin rsp_valid = 1'b1; rsp_hit        = 1'b1; end
            RS_MISS:  begin rsp_valid = 1'b1; rsp_miss       = 1'b1; end
            RS_FAULT: begin rsp_valid = 1'b1; rsp_fault      = 1'b1; end
            RS_DIRTY: begin rsp_valid = 1'b1; rsp_dirty_miss = 1'b1; end
            default:  ;
        endcase
    end
    assign rsp_paddr = paddr_q;

endmodule

// File: rtl/tlb_xlate_chk.sv
`timescale 1ns/1ps
module tlb_xlate_chk #(
    parameter int ENTRIES = 8,
    parameter int VA_W    = 43,
    parameter int OFF_W   = 13,
    parameter int PPN_W   = 21,
    parameter int ASID_W  = 8,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PA_W   = PPN_W + OFF_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [VA_W-1:0]    req_vaddr,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_miss,
    input logic               rsp_fault,
    input logic               rsp_dirty_miss,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic               flush_all,
    input logic               flush_asid_en,
    input logic [ASID_W-1:0]  flush_asid,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [VPN_W-1:0]   vpn_arr  [ENTRIES],
    input logic [ASID_W-1:0]  asid_arr [ENTRIES]
);
    logic              dup_seen;
    logic              sel_flush_q;
    logic [ASID_W-1:0] sel_asid_q;
    logic              stale_left;

    always_comb begin
        dup_seen = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            for (int j = i + 1; j < ENTRIES; j++) begin
                if (valid_vec[i] && valid_vec[j]
                    && vpn_arr[i] == vpn_arr[j] && asid_arr[i] == asid_arr[j])
                    dup_seen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_flush_q <= 1'b0;
            sel_asid_q  <= '0;
        end else begin
            sel_flush_q <= flush_asid_en && !flush_all;
            sel_asid_q  <= flush_asid;
        end
    end

    always_comb begin
        stale_left = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (valid_vec[i] && asid_arr[i] == sel_asid_q) stale_left = 1'b1;
        end
    end

    a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_miss, rsp_fault, rsp_dirty_miss})
        && (rsp_valid == (rsp_hit | rsp_miss | rsp_fault | rsp_dirty_miss)));

    a_r2_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r2_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

    a_r6_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_vec == '0));

    a_r7_asid_gone: assert property (@(posedge clk) disable iff (!rst_n)
        sel_flush_q |-> !stale_left);

    a_r8_unique: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_seen);

endmodule

bind tlb_xlate_top tlb_xlate_chk #(
    .ENTRIES (ENTRIES),
    .VA_W    (VA_W),
    .OFF_W   (OFF_W),
    .PPN_W   (PPN_W),
    .ASID_W  (ASID_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_vaddr      (req_vaddr),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_miss       (rsp_miss),
    .rsp_fault      (rsp_fault),
    .rsp_dirty_miss (rsp_dirty_miss),
    .rsp_paddr      (rsp_paddr),
    .flush_all      (flush_all),
    .flush_asid_en  (flush_asid_en),
    .flush_asid     (flush_asid),
    .valid_vec      (valid_vec),
    .vpn_arr        (vpn_arr),
    .asid_arr       (asid_arr)
);

// File: tb/sim_tlb_xlate_top.sv
`timescale 1ns/1ps
module sim_tlb_xlate_top;
    localparam int ENTRIES = 8;
    localparam int VA_W    = 43;
    localparam int OFF_W   = 13;
    localparam int PPN_W   = 21;
    localparam int ASID_W  = 8;
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int PA_W    = PPN_W + OFF_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [VA_W-1:0]   req_vaddr = '0;
    logic [ASID_W-1:0] req_asid = '0;
    logic [1:0]        req_acc = '0;
    logic              rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty_miss;
    logic [PA_W-1:0]   rsp_paddr;
    logic              fill_valid = 1'b0;
    logic [VPN_W-1:0]  fill_vpn = '0;
    logic [ASID_W-1:0] fill_asid = '0;
    logic [PPN_W-1:0]  fill_ppn = '0;
    logic [2:0]        fill_perm = '0;
    logic              fill_dirty = 1'b0;
    logic              flush_all = 1'b0;
    logic              flush_asid_en = 1'b0;
    logic [ASID_W-1:0] flush_asid = '0;

    int n_chk = 0;
    int n_bad = 0;

    // Captured response of the last lookup: 0 idle, 1 hit, 2 miss, 3 fault, 4 dirty
    int              got_kind;
    logic [PA_W-1:0] got_pa;

    always #10 clk = ~clk;   // 20 ns period, 50 MHz

    tlb_xlate_top u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_asid(req_asid), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_dirty_miss(rsp_dirty_miss), .rsp_paddr(rsp_paddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_ppn(fill_ppn), .fill_perm(fill_perm), .fill_dirty(fill_dirty),
        .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                        input logic [PPN_W-1:0] ppn, input logic [2:0] perm, input logic dirty);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_asid = asid;
        fill_ppn = ppn; fill_perm = perm; fill_dirty = dirty;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_flush_all();
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
    endtask

    task automatic do_flush_asid(input logic [ASID_W-1:0] a);
        @(negedge clk);
        flush_asid_en = 1'b1; flush_asid = a;
        @(negedge clk);
        flush_asid_en = 1'b0;
    endtask

    // Drive at a falling edge, response is registered at the next rising edge,
    // sampled at the following falling edge.
    task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                          input logic [ASID_W-1:0] asid, input logic [1:0] acc);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = {vpn, off}; req_asid = asid; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        got_pa = rsp_paddr;
        if (!rsp_valid)          got_kind = 0;
        else if (rsp_hit)        got_kind = 1;
        else if (rsp_miss)       got_kind = 2;
        else if (rsp_fault)      got_kind = 3;
        else if (rsp_dirty_miss) got_kind = 4;
        else                     got_kind = 9;
    endtask

    task automatic expect_kind(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                               input logic [1:0] acc, input int kind, input string req);
        lookup(vpn, 13'h0, asid, acc);
        check(got_kind == kind, req, got_kind, kind);
    endtask

    task automatic expect_hit_pa(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                                 input logic [ASID_W-1:0] asid, input logic [PPN_W-1:0] ppn,
                                 input string req);
        lookup(vpn, off, asid, 2'd0);
        check(got_kind == 1, req, got_kind, 1);
        check(got_pa == {ppn, off}, req, got_pa, {ppn, off});
    endtask

    task automatic t_reset();
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
        expect_kind(30'h0, 8'h0, 2'd0, 2, "R1 first lookup misses");
    endtask

    task automatic t_basic_hit();
        fill(30'h12345, 8'h01, 21'h0ABCD, 3'b111, 1'b1);
        expect_hit_pa(30'h12345, 13'h1A5, 8'h01, 21'h0ABCD, "R2 hit address");
        @(negedge clk);
        check(rsp_valid == 1'b0, "R2 response lasts one cycle", rsp_valid, 0);
        expect_kind(30'h54321, 8'h01, 2'd0, 2, "R11 unknown page misses");
    endtask

    task automatic t_asid();
        expect_kind(30'h12345, 8'h02, 2'd0, 2, "R3 other identifier misses");
        fill(30'h12345, 8'h02, 21'h1F00F, 3'b111, 1'b1);
        expect_hit_pa(30'h12345, 13'h0007, 8'h02, 21'h1F00F, "R3 second identifier");
        expect_hit_pa(30'h12345, 13'h1FFF, 8'h01, 21'h0ABCD, "R3 first identifier kept");
    endtask

    task automatic t_prot();
        fill(30'h200, 8'h03, 21'h00200, 3'b001, 1'b1);
        expect_kind(30'h200, 8'h03, 2'd0, 1, "R4 read allowed");
        expect_kind(30'h200, 8'h03, 2'd1, 3, "R4 write forbidden");
        expect_kind(30'h200, 8'h03, 2'd2, 3, "R4 execute forbidden");
        fill(30'h201, 8'h03, 21'h00201, 3'b100, 1'b1);
        expect_kind(30'h201, 8'h03, 2'd2, 1, "R4 execute allowed");
        expect_kind(30'h201, 8'h03, 2'd0, 3, "R4 read forbidden");
        fill(30'h202, 8'h03, 21'h00202, 3'b111, 1'b1);
        expect_kind(30'h202, 8'h03, 2'd3, 3, "R4 reserved code faults");
    endtask

    task automatic t_dirty();
        fill(30'h300, 8'h03, 21'h00300, 3'b011, 1'b0);
        expect_kind(30'h300, 8'h03, 2'd1, 4, "R5 clean write dirty-miss");
        expect_kind(30'h300, 8'h03, 2'd0, 1, "R5 clean read hits");
        fill(30'h300, 8'h03, 21'h00300, 3'b011, 1'b1);
        expect_kind(30'h300, 8'h03, 2'd1, 1, "R5 dirty write hits");
        fill(30'h301, 8'h03, 21'h00301, 3'b001, 1'b0);
        expect_kind(30'h301, 8'h03, 2'd1, 3, "R5 fault before dirty");
    endtask

    task automatic t_flush_all();
        do_flush_all();
        expect_kind(30'h12345, 8'h01, 2'd0, 2, "R6 entry gone after flush");
        expect_kind(30'h200, 8'h03, 2'd0, 2, "R6 entry gone after flush");
        @(negedge clk);
        flush_all = 1'b1;
        fill_valid = 1'b1; fill_vpn = 30'h777; fill_asid = 8'h04;
        fill_ppn = 21'h777; fill_perm = 3'b111; fill_dirty = 1'b1;
        @(negedge clk);
        flush_all = 1'b0; fill_valid = 1'b0;
        expect_kind(30'h777, 8'h04, 2'd0, 2, "R6 fill during flush dropped");
    endtask

    task automatic t_flush_asid();
        fill(30'h400, 8'h05, 21'h00400, 3'b111, 1'b1);
        fill(30'h401, 8'h06, 21'h00401, 3'b111, 1'b1);
        fill(30'h402, 8'h05, 21'h00402, 3'b111, 1'b1);
        do_flush_asid(8'h05);
        expect_kind(30'h400, 8'h05, 2'd0, 2, "R7 flushed identifier misses");
        expect_kind(30'h402, 8'h05, 2'd0, 2, "R7 flushed identifier misses");
        expect_hit_pa(30'h401, 13'h0100, 8'h06, 21'h00401, "R7 other identifier kept");
    endtask

    task automatic t_dup_fill();
        do_flush_all();
        fill(30'h500, 8'h07, 21'h00501, 3'b111, 1'b1);
        fill(30'h500, 8'h07, 21'h00502, 3'b111, 1'b1);
        for (int i = 0; i < ENTRIES - 1; i++)
            fill(30'h510 + 30'(i), 8'h07, 21'h00510 + 21'(i), 3'b111, 1'b1);
        expect_hit_pa(30'h500, 13'h0, 8'h07, 21'h00502, "R8 overwrite keeps new ppn");
        for (int i = 0; i < ENTRIES - 1; i++)
            expect_kind(30'h510 + 30'(i), 8'h07, 2'd0, 1, "R8 no slot consumed");
    endtask

    task automatic t_round_robin();
        do_flush_all();
        for (int i = 0; i < ENTRIES; i++)
            fill(30'h600 + 30'(i), 8'h08, 21'h00600 + 21'(i), 3'b111, 1'b1);
        fill(30'h6F0, 8'h08, 21'h006F0, 3'b111, 1'b1);
        fill(30'h6F1, 8'h08, 21'h006F1, 3'b111, 1'b1);
        expect_kind(30'h600, 8'h08, 2'd0, 2, "R10 entry 0 evicted");
        expect_kind(30'h601, 8'h08, 2'd0, 2, "R10 entry 1 evicted next");
        expect_kind(30'h602, 8'h08, 2'd0, 1, "R10 entry 2 kept");
        expect_kind(30'h6F0, 8'h08, 2'd0, 1, "R10 new page present");
        expect_kind(30'h6F1, 8'h08, 2'd0, 1, "R10 new page present");
    endtask

    task automatic t_first_free();
        do_flush_all();
        for (int i = 0; i < ENTRIES; i++)
            fill(30'h700 + 30'(i), (i == 3) ? 8'h09 : 8'h08, 21'h00700 + 21'(i), 3'b111, 1'b1);
        do_flush_asid(8'h09);
        fill(30'h7A0, 8'h08, 21'h007A0, 3'b111, 1'b1);
        expect_kind(30'h700, 8'h08, 2'd0, 1, "R9 hole used, entry 0 kept");
        fill(30'h7A1, 8'h08, 21'h007A1, 3'b111, 1'b1);
        expect_kind(30'h700, 8'h08, 2'd0, 2, "R10 pointer unmoved, entry 0 evicted");
        expect_kind(30'h701, 8'h08, 2'd0, 1, "R9 entry 1 kept");
        expect_kind(30'h7A0, 8'h08, 2'd0, 1, "R9 hole fill present");
        expect_kind(30'h7A1, 8'h08, 2'd0, 1, "R10 new page present");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_hit();
        t_asid();
        t_prot();
        t_dirty();
        t_flush_all();
        t_flush_asid();
        t_dup_fill();
        t_round_robin();
        t_first_free();
        repeat (2) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule